// File: doc/BRIEF.md
# ALU Operand Forwarding Unit

This block sits beside the Compute stage of a five-stage in-order pipeline (Fetch, Decode, Compute, Memory, Write Back). It keeps its own copy of the register tags that travel down the pipeline: which registers each instruction reads, which register it writes, and whether it is a load. From these tags it decides, for each of the two ALU inputs, whether the operand comes from the register file, from the result buffer after Compute, or from the result buffer after Memory. It then drives the two operand multiplexers. When two older instructions both write the register being read, the younger one wins.

A loaded value first appears in the buffer after the Memory stage. An instruction in Decode that reads the destination of a load now in Compute therefore cannot be served by forwarding in the next cycle. The block raises a hold request that freezes Fetch and Decode for one cycle, and it loads an empty slot (a bubble) into its Compute-stage tags. One cycle later the load result is forwarded from the Write Back-side buffer. The surrounding pipeline presents the Decode-stage tags and the three data values (register file values for the Compute instruction and the two buffer results), and it honours the hold request.

Top module: `fwd_unit`

## Requirements
- R1: During and right after synchronous reset the block tracks no producer: `hold_front` is 0, both selects are 00 and each ALU input equals its register-file value.
- R2: When the instruction in the Memory stage writes a nonzero register equal to a source that the Compute instruction uses, that operand's select is 01 and its ALU input equals `mem_val`.
- R3: When only the instruction in the Write Back stage writes a nonzero register equal to a used source, the select is 10 and the ALU input equals `wb_val`.
- R4: When both the Memory-stage and the Write Back-stage instructions write the same used source register, the Memory-stage producer wins: select 01.
- R5: No forwarding takes place (select 00) from a producer that does not write a register, from a producer whose destination is register 0, or for a source whose use flag is 0.
- R6: `hold_front` is 1 exactly in a cycle where the instruction in Compute is a load with a nonzero destination and the instruction in Decode uses that register as either source.
- R7: In the cycle after `hold_front` is 1, the Compute slot holds a bubble: `hold_front` is 0 and both selects are 00, even though Decode still presents the held instruction.
- R8: Two cycles after a hold, the held instruction is in Compute and the load is in Write Back; the dependent operand gets select 10 and never 01.
- R9: A select is never 11. Each ALU input always equals the source its select names: 00 register file, 01 Memory-stage buffer, 10 Write Back-stage buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | REG_W | First source register of the Decode instruction |
| dec_src_b | input | REG_W | Second source register of the Decode instruction |
| dec_use_a | input | 1 | Decode instruction reads its first source |
| dec_use_b | input | 1 | Decode instruction reads its second source |
| dec_dst | input | REG_W | Destination register of the Decode instruction |
| dec_wr | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| rf_val_a | input | XLEN | Register-file value of the Compute instruction's first source |
| rf_val_b | input | XLEN | Register-file value of the Compute instruction's second source |
| mem_val | input | XLEN | Result held in the buffer after Compute |
| wb_val | input | XLEN | Result held in the buffer after Memory (ALU or load data) |
| hold_front | output | 1 | Hold Fetch and Decode for this cycle; a bubble enters Compute |
| sel_a | output | 2 | Forwarding select of the first ALU input |
| sel_b | output | 2 | Forwarding select of the second ALU input |
| alu_in_a | output | XLEN | First ALU operand after forwarding |
| alu_in_b | output | XLEN | Second ALU operand after forwarding |

## Verification
Some properties are checked on every cycle: the select code stays legal, a 01 or 10 select comes only from a writing producer with a nonzero destination and carries that buffer's value, the cycle after a hold carries a bubble, and two cycles after a hold no operand is taken from the Memory stage. Other behaviour only the bench scenarios can show. This covers the priority when both producers match, the suppression for non-writing producers and register 0, the exact condition that raises a hold, and that the held instruction is later served from the Write Back-side buffer. The bench shows these by running directed instruction sequences and a long stream of random tags against its reference pipeline model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // operand source select encoding
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } src_sel_e;

endpackage

// File: rtl/fwd_tag_pipe.sv
module fwd_tag_pipe #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bubble,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_use_a,
  input  logic             dec_use_b,
  input  logic [REG_W-1:0] dec_dst,
  input  logic             dec_wr,
  input  logic             dec_load,
  output logic [REG_W-1:0] ex_src_a,
  output logic [REG_W-1:0] ex_src_b,
  output logic             ex_use_a,
  output logic             ex_use_b,
  output logic [REG_W-1:0] ex_dst,
  output logic             ex_wr,
  output logic             ex_load,
  output logic [REG_W-1:0] mem_dst,
  output logic             mem_wr,
  output logic [REG_W-1:0] wb_dst,
  output logic             wb_wr
);

  // Compute-stage tags: a bubble clears every effect of the slot
  always_ff @(posedge clk) begin
    if (rst || bubble) begin
      ex_src_a <= '0;
      ex_src_b <= '0;
      ex_use_a <= 1'b0;
      ex_use_b <= 1'b0;
      ex_dst   <= '0;
      ex_wr    <= 1'b0;
      ex_load  <= 1'b0;
    end else begin
      ex_src_a <= dec_src_a;
      ex_src_b <= dec_src_b;
      ex_use_a <= dec_use_a;
      ex_use_b <= dec_use_b;
      ex_dst   <= dec_dst;
      ex_wr    <= dec_wr;
      ex_load  <= dec_load;
    end
  end

  // Memory and Write Back tags always advance
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_dst <= '0;
      mem_wr  <= 1'b0;
      wb_dst  <= '0;
      wb_wr   <= 1'b0;
    end else begin
      mem_dst <= ex_dst;
      mem_wr  <= ex_wr;
      wb_dst  <= mem_dst;
      wb_wr   <= mem_wr;
    end
  end

endmodule

// File: rtl/fwd_load_use.sv
module fwd_load_use #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr,
  input  logic             ex_load,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_use_a,
  input  logic             dec_use_b,
  output logic             hold
);

  logic producer_live;
  logic hit_a, hit_b;

  always_comb begin
    producer_live = ex_load && ex_wr && (ex_dst != '0);
    hit_a = dec_use_a && (dec_src_a == ex_dst);
    hit_b = dec_use_b && (dec_src_b == ex_dst);
    hold  = producer_live && (hit_a || hit_b);
  end

endmodule

// File: rtl/fwd_operand.sv
module fwd_operand
  import fwd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int XLEN  = 32
) (
  input  logic [REG_W-1:0] src,
  input  logic             use_src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  input  logic [XLEN-1:0]  rf_val,
  input  logic [XLEN-1:0]  mem_val,
  input  logic [XLEN-1:0]  wb_val,
  output logic [1:0]       sel,
  output logic [XLEN-1:0]  val
);

  logic     mem_hit, wb_hit;
  src_sel_e pick;

  always_comb begin
    mem_hit = use_src && mem_wr && (mem_dst != '0) && (mem_dst == src);
    wb_hit  = use_src && wb_wr  && (wb_dst  != '0) && (wb_dst  == src);
    // younger producer first
    if (mem_hit)     pick = SRC_MEM;
    else if (wb_hit) pick = SRC_WB;
    else             pick = SRC_RF;
  end

  always_comb begin
    unique case (pick)
      SRC_MEM: val = mem_val;
      SRC_WB:  val = wb_val;
      default: val = rf_val;
    endcase
    sel = pick;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int REG_W = 5,
  parameter int XLEN  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic             dec_use_a,
  input  logic             dec_use_b,
  input  logic [REG_W-1:0] dec_dst,
  input  logic             dec_wr,
  input  logic             dec_load,
  input  logic [XLEN-1:0]  rf_val_a,
  input  logic [XLEN-1:0]  rf_val_b,
  input  logic [XLEN-1:0]  mem_val,
  input  logic [XLEN-1:0]  wb_val,
  output logic             hold_front,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [XLEN-1:0]  alu_in_a,
  output logic [XLEN-1:0]  alu_in_b
);

  localparam int NUM_OPS = 2;

  logic [REG_W-1:0] ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic             ex_use_a, ex_use_b, ex_wr, ex_load, mem_wr, wb_wr;

  logic [REG_W-1:0] op_src [NUM_OPS];
  logic             op_use [NUM_OPS];
  logic [XLEN-1:0]  op_rf  [NUM_OPS];
  logic [1:0]       op_sel [NUM_OPS];
  logic [XLEN-1:0]  op_val [NUM_OPS];

  fwd_tag_pipe #(.REG_W(REG_W)) u_tags (
    .clk       (clk),
    .rst       (rst),
    .bubble    (hold_front),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .dec_use_a (dec_use_a),
    .dec_use_b (dec_use_b),
    .dec_dst   (dec_dst),
    .dec_wr    (dec_wr),
    .dec_load  (dec_load),
    .ex_src_a  (ex_src_a),
    .ex_src_b  (ex_src_b),
    .ex_use_a  (ex_use_a),
    .ex_use_b  (ex_use_b),
    .ex_dst    (ex_dst),
    .ex_wr     (ex_wr),
    .ex_load   (ex_load),
    .mem_dst   (mem_dst),
    .mem_wr    (mem_wr),
    .wb_dst    (wb_dst),
    .wb_wr     (wb_wr)
  );

  fwd_load_use #(.REG_W(REG_W)) u_hazard (
    .ex_dst    (ex_dst),
    .ex_wr     (ex_wr),
    .ex_load   (ex_load),
    .dec_src_a (dec_src_a),
    .dec_src_b (dec_src_b),
    .dec_use_a (dec_use_a),
    .dec_use_b (dec_use_b),
    .hold      (hold_front)
  );

  always_comb begin
    op_src[0] = ex_src_a;
    op_src[1] = ex_src_b;
    op_use[0] = ex_use_a;
    op_use[1] = ex_use_b;
    op_rf[0]  = rf_val_a;
    op_rf[1]  = rf_val_b;
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_operand #(.REG_W(REG_W), .XLEN(XLEN)) u_op (
      .src     (op_src[g]),
      .use_src (op_use[g]),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_wr),
      .rf_val  (op_rf[g]),
      .mem_val (mem_val),
      .wb_val  (wb_val),
      .sel     (op_sel[g]),
      .val     (op_val[g])
    );
  end

  assign sel_a    = op_sel[0];
  assign sel_b    = op_sel[1];
  assign alu_in_a = op_val[0];
  assign alu_in_b = op_val[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W = 5,
  parameter int XLEN  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             hold_front,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic [XLEN-1:0]  alu_in_a,
  input logic [XLEN-1:0]  alu_in_b,
  input logic [XLEN-1:0]  mem_val,
  input logic [XLEN-1:0]  wb_val,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wr
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hold_front && sel_a == 2'b00 && sel_b == 2'b00)); // R1

  AST_MEM_SRC_A: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b01) |-> (mem_wr && mem_dst != '0 && alu_in_a == mem_val)); // R2

  AST_MEM_SRC_B: assert property (@(posedge clk) disable iff (rst)
    (sel_b == 2'b01) |-> (mem_wr && mem_dst != '0 && alu_in_b == mem_val)); // R2

  AST_WB_SRC_A: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b10) |-> (wb_wr && wb_dst != '0 && alu_in_a == wb_val)); // R3

  AST_WB_SRC_B: assert property (@(posedge clk) disable iff (rst)
    (sel_b == 2'b10) |-> (wb_wr && wb_dst != '0 && alu_in_b == wb_val)); // R3

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11 && sel_b != 2'b11)); // R9

  AST_BUBBLE_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_front |=> (!hold_front && sel_a == 2'b00 && sel_b == 2'b00)); // R7

  AST_NO_MEM_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    hold_front |=> ##1 (sel_a != 2'b01 && sel_b != 2'b01)); // R8

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .hold_front (hold_front),
  .sel_a      (sel_a),
  .sel_b      (sel_b),
  .alu_in_a   (alu_in_a),
  .alu_in_b   (alu_in_b),
  .mem_val    (mem_val),
  .wb_val     (wb_val),
  .mem_dst    (mem_dst),
  .mem_wr     (mem_wr),
  .wb_dst     (wb_dst),
  .wb_wr      (wb_wr)
);

// File: tb/fwd_unit_test.sv
`timescale 1ns/1ps
module fwd_unit_test;

  localparam int REG_W = 5;
  localparam int XLEN  = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [REG_W-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic             dec_use_a = 1'b0, dec_use_b = 1'b0, dec_wr = 1'b0, dec_load = 1'b0;
  logic [XLEN-1:0]  rf_val_a = '0, rf_val_b = '0, mem_val = '0, wb_val = '0;
  logic             hold_front;
  logic [1:0]       sel_a, sel_b;
  logic [XLEN-1:0]  alu_in_a, alu_in_b;

  always #2.5 clk = ~clk;

  fwd_unit #(.REG_W(REG_W), .XLEN(XLEN)) uut (
    .clk(clk), .rst(rst),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_use_a(dec_use_a), .dec_use_b(dec_use_b),
    .dec_dst(dec_dst), .dec_wr(dec_wr), .dec_load(dec_load),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .mem_val(mem_val), .wb_val(wb_val),
    .hold_front(hold_front), .sel_a(sel_a), .sel_b(sel_b),
    .alu_in_a(alu_in_a), .alu_in_b(alu_in_b)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // reference pipeline model: one record per stage
  typedef struct {
    int sa; int sb; bit ua; bit ub; int dst; bit wr; bit ld;
  } slot_t;

  slot_t m_ex, m_mem, m_wb;
  bit    stall_d1, stall_d2, first_cycle;

  function automatic slot_t empty_slot();
    slot_t s;
    s.sa = 0; s.sb = 0; s.ua = 0; s.ub = 0; s.dst = 0; s.wr = 0; s.ld = 0;
    return s;
  endfunction

  function automatic bit hits(slot_t p, int src, bit used);
    return used && p.wr && p.dst != 0 && p.dst == src;
  endfunction

  function automatic int exp_sel(int src, bit used);
    if (hits(m_mem, src, used)) return 1;
    if (hits(m_wb, src, used))  return 2;
    return 0;
  endfunction

  function automatic string sel_tag(int src, bit used);
    if (first_cycle) return "R1";
    if (stall_d1)    return "R7";
    if (stall_d2)    return "R8";
    if (hits(m_mem, src, used) && hits(m_wb, src, used)) return "R4";
    if (hits(m_mem, src, used)) return "R2";
    if (hits(m_wb, src, used))  return "R3";
    return "R5";
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_stall();
    return m_ex.ld && m_ex.wr && m_ex.dst != 0 &&
           ((dec_use_a && int'(dec_src_a) == m_ex.dst) ||
            (dec_use_b && int'(dec_src_b) == m_ex.dst));
  endfunction

  // compare every output of the current cycle against the model
  task automatic check_cycle(output bit st);
    int ea, eb;
    longint va, vb;
    st = exp_stall();
    ea = exp_sel(m_ex.sa, m_ex.ua);
    eb = exp_sel(m_ex.sb, m_ex.ub);
    va = (ea == 1) ? mem_val : (ea == 2) ? wb_val : rf_val_a;
    vb = (eb == 1) ? mem_val : (eb == 2) ? wb_val : rf_val_b;
    check(first_cycle ? "R1" : (stall_d1 ? "R7" : "R6"), "hold_front", hold_front, st);
    check(sel_tag(m_ex.sa, m_ex.ua), "sel_a", sel_a, ea);
    check(sel_tag(m_ex.sb, m_ex.ub), "sel_b", sel_b, eb);
    check("R9", "alu_in_a", alu_in_a, va);
    check("R9", "alu_in_b", alu_in_b, vb);
  endtask

  task automatic advance(bit st);
    slot_t d;
    d.sa = dec_src_a; d.sb = dec_src_b; d.ua = dec_use_a; d.ub = dec_use_b;
    d.dst = dec_dst; d.wr = dec_wr; d.ld = dec_load;
    m_wb  = m_mem;
    m_mem = m_ex;
    m_ex  = st ? empty_slot() : d;
    stall_d2    = stall_d1;
    stall_d1    = st;
    first_cycle = 1'b0;
  endtask

  // present one instruction in Decode until it is accepted
  task automatic issue(int sa, int sb, bit ua, bit ub, int dst, bit wr, bit ld);
    bit st;
    do begin
      dec_src_a = sa[REG_W-1:0]; dec_src_b = sb[REG_W-1:0];
      dec_use_a = ua; dec_use_b = ub;
      dec_dst = dst[REG_W-1:0]; dec_wr = wr; dec_load = ld;
      rf_val_a = $urandom; rf_val_b = $urandom;
      mem_val  = $urandom; wb_val   = $urandom;
      #1;
      check_cycle(st);
      @(posedge clk);
      advance(st);
      @(negedge clk);
    end while (st);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    m_ex = empty_slot(); m_mem = empty_slot(); m_wb = empty_slot();
    stall_d1 = 0; stall_d2 = 0; first_cycle = 1;
    // drive a dependent pattern during reset: R1 nothing may be tracked
    dec_src_a = 5'd3; dec_use_a = 1; dec_dst = 5'd3; dec_wr = 1; dec_load = 1;
    rf_val_a = 32'h1111_0000; rf_val_b = 32'h2222_0000;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", "hold_front in reset", hold_front, 0);
    check("R1", "sel_a in reset", sel_a, 0);
    check("R1", "alu_in_a in reset", alu_in_a, 32'h1111_0000);
    check("R1", "alu_in_b in reset", alu_in_b, 32'h2222_0000);
    rst = 1'b0;
    dec_load = 0;

    // R2: back-to-back ALU dependency
    issue(1, 2, 1, 1, 2, 1, 0);
    issue(2, 7, 1, 1, 9, 1, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    // R3: producer two older
    issue(4, 4, 1, 1, 5, 1, 0);
    issue(8, 8, 1, 1, 10, 1, 0);
    issue(6, 5, 1, 1, 11, 1, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    // R4: two producers of the same register
    issue(1, 1, 1, 1, 3, 1, 0);
    issue(1, 1, 1, 1, 3, 1, 0);
    issue(3, 3, 1, 1, 12, 1, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    // R5: register 0, non-writing producer, unused source
    issue(1, 1, 1, 1, 0, 1, 0);
    issue(0, 0, 1, 1, 4, 0, 0);
    issue(4, 0, 1, 1, 13, 1, 0);
    issue(13, 13, 0, 0, 14, 1, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    // R6 R7 R8: load followed by a user of its result
    issue(1, 2, 1, 1, 5, 1, 1);
    issue(7, 5, 1, 1, 15, 1, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    // load then independent then user: no hold, forward from Write Back
    issue(1, 2, 1, 1, 6, 1, 1);
    issue(9, 9, 1, 1, 16, 1, 0);
    issue(6, 6, 1, 1, 17, 1, 0);
    // load into register 0 and a load whose reader has use flags off
    issue(1, 2, 1, 1, 0, 1, 1);
    issue(0, 0, 1, 1, 18, 1, 0);
    issue(3, 4, 1, 1, 7, 1, 1);
    issue(7, 7, 0, 0, 19, 1, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);

    // random stream with few registers to provoke hazards
    for (int i = 0; i < 600; i++) begin
      issue(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 3)), bit'($urandom_range(0, 3) != 0),
            bit'($urandom_range(0, 2) == 0));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule